// File: doc/BRIEF.md
# Serial PHY Management Master

This block is the master side of a two-wire PHY management bus. Software writes one 32-bit command word. The block then sends a serial frame on the management clock and data lines. The frame starts with a run of ones, then carries the command word most significant bit first. A status output stays low for the whole frame and goes high again when the frame ends. For a read, the master releases the data line from the turnaround bits onward. It captures the sixteen bits the PHY returns into the low half of the same command word, and software reads them back from there.

The management clock is made from the system clock by a divider. A two-bit selector picks one of four ratios: 8, 16, 32 or 64. Software should pick 8 for system clocks up to 20 MHz, 16 up to 40 MHz, 32 up to 80 MHz and 64 above 80 MHz. A port-enable input gates everything. While it is low, commands are not accepted, and a frame in flight is cut short.

The sequencer walks through five states:
- `ST_IDLE`: waits for a command. It moves to `ST_PREAMBLE` on an accepted write.
- `ST_PREAMBLE`: sends the ones. It moves to `ST_HEADER` after the last one.
- `ST_HEADER`: sends command bits 31..18. It moves to `ST_TURN` after bit 18.
- `ST_TURN`: covers bits 17..16. It moves to `ST_DATA` after bit 16.
- `ST_DATA`: covers bits 15..0. It moves back to `ST_IDLE` after bit 0.

From any busy state, a low enable forces the move to `ST_IDLE`.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, `idle` is 1, `mdc` is 0, `mdio_oe` is 0, `mdio_o` is 0 and `cmd_rdata` is all zeros.
- R2: A `cmd_wr` pulse seen at a clock edge while `idle` is 1 and `mgmt_en` is 1 makes `idle` 0 from the next cycle on. From that same cycle, `cmd_rdata` equals the written word.
- R3: Each serial bit lasts D system clocks, where D = 8 << `mdc_sel` (selector 0,1,2,3 gives 8,16,32,64). `mdc` is 0 for the first D/2 clocks of a bit and 1 for the last D/2. D is taken from `mdc_sel` at launch, and later changes of `mdc_sel` do not affect the frame in flight.
- R4: A frame is 32 bit periods of `mdio_o`=1 with `mdio_oe`=1, followed by command bits 31 down to 0. The command word fields are: [31:30] start, [29:28] opcode, [27:23] PHY address, [22:18] register address, [17:16] turnaround code, [15:0] data.
- R5: When the opcode field holds 2'b10 (read), `mdio_oe` is 0 for frame bits 17 down to 0. For any other opcode it stays 1 for the whole frame.
- R6: On a read, `mdio_i` is sampled at the system clock edge where `mdc` goes from 0 to 1 during frame bits 15..0. Each sample is written into the same bit position of `cmd_rdata`. Bits 31:16 keep their written value.
- R7: `idle` returns to 1 exactly 64·D cycles after it went low. A frame that is not a read leaves `cmd_rdata` unchanged.
- R8: A `cmd_wr` while `idle` is 0 is ignored. The frame in flight and `cmd_rdata[31:16]` are unaffected.
- R9: While `mgmt_en` is 0, `cmd_wr` starts nothing. If `mgmt_en` falls during a frame, then from the next cycle `idle` is 1, `mdc` is 0 and `mdio_oe` is 0.
- R10: `mdio_o` is 0 whenever `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgmt_en | input | 1 | Management port enable |
| mdc_sel | input | 2 | Divider select: ratio 8 << value |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Current command word, with read data in [15:0] |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven to the PHY |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Data returned by the PHY |

## Verification
The bench builds the block with its default parameters. These are a base divider exponent of 3, a 32-bit preamble and a two-bit selector, so all four ratios from 8 to 64 are reachable, and the bench runs frames at each of them. With a 64-clock bit, a read frame takes 4096 cycles. That is short enough that the bench can compare every output on every cycle for reads, writes, aborted frames and a selector change in the middle of a frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PREAMBLE = 3'd1,
        ST_HEADER   = 3'd2,
        ST_TURN     = 3'd3,
        ST_DATA     = 3'd4
    } mdio_state_e;

    localparam int CMD_W = 32;
    localparam int IDX_W = $clog2(CMD_W);

    // Field positions that the sequencer itself decodes
    localparam int OP_HI = 29;
    localparam int OP_LO = 28;
    localparam int TA_HI = 17;
    localparam int TA_LO = 16;

    localparam logic [1:0] OP_READ = 2'b10;

endpackage

// File: rtl/mdio_phase_gen.sv
module mdio_phase_gen #(
    parameter int DIV_BASE_LOG2 = 3,
    parameter int SEL_W         = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             rise_tick,
    output logic             bit_end
);
    localparam int PH_W = DIV_BASE_LOG2 + (1 << SEL_W) - 1;

    logic [SEL_W-1:0] sel_q;
    logic [PH_W-1:0]  phase;
    logic [PH_W:0]    div_full;
    logic [PH_W-1:0]  div_m1;
    logic [PH_W-1:0]  half;
    logic [PH_W-1:0]  half_m1;

    always_comb begin
        div_full  = {{PH_W{1'b0}}, 1'b1} << (DIV_BASE_LOG2 + int'(sel_q));
        div_m1    = div_full[PH_W-1:0] - PH_W'(1);
        half      = div_full[PH_W:1];
        half_m1   = half - PH_W'(1);
        rise_tick = run && (phase == half_m1);
        bit_end   = run && (phase == div_m1);
        mdc       = run && (phase >= half);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            phase <= '0;
        end else if (start) begin
            sel_q <= sel;
            phase <= '0;
        end else if (run) begin
            phase <= bit_end ? '0 : phase + PH_W'(1);
        end else begin
            phase <= '0;
        end
    end

    AST_RISE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> (mdc || !run));  // R3

    AST_END_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> !mdc);  // R3

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             bit_end,
    input  logic             is_read,
    input  logic             tx_bit,
    output mdio_state_e      state,
    output logic [IDX_W-1:0] bit_idx,
    output logic             mdio_o,
    output logic             mdio_oe
);
    localparam int CNT_MAX = (PRE_LEN > CMD_W) ? PRE_LEN : CMD_W;
    localparam int CNT_W   = $clog2(CNT_MAX);

    mdio_state_e      state_n;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_n;

    assign bit_idx = cnt[IDX_W-1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Transitions
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n = ST_PREAMBLE;
                    cnt_n   = CNT_W'(PRE_LEN - 1);
                end
            end
            ST_PREAMBLE: begin
                if (bit_end) begin
                    if (cnt == '0) begin
                        state_n = ST_HEADER;
                        cnt_n   = CNT_W'(CMD_W - 1);
                    end else begin
                        cnt_n = cnt - CNT_W'(1);
                    end
                end
            end
            ST_HEADER: begin
                if (bit_end) begin
                    cnt_n = cnt - CNT_W'(1);
                    if (cnt == CNT_W'(TA_HI + 1)) state_n = ST_TURN;
                end
            end
            ST_TURN: begin
                if (bit_end) begin
                    cnt_n = cnt - CNT_W'(1);
                    if (cnt == CNT_W'(TA_LO)) state_n = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    if (cnt == '0) state_n = ST_IDLE;
                    else           cnt_n   = cnt - CNT_W'(1);
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (abort && (state != ST_IDLE)) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
        end
    end

    // Outputs
    always_comb begin
        mdio_oe = 1'b0;
        mdio_o  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                mdio_oe = 1'b0;
            end
            ST_PREAMBLE: begin
                mdio_oe = 1'b1;
                mdio_o  = 1'b1;
            end
            ST_HEADER: begin
                mdio_oe = 1'b1;
                mdio_o  = tx_bit;
            end
            ST_TURN, ST_DATA: begin
                if (!is_read) begin
                    mdio_oe = 1'b1;
                    mdio_o  = tx_bit;
                end
            end
            default: mdio_oe = 1'b0;
        endcase
    end

    AST_HEADER_FROM_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HEADER && $past(state) != ST_HEADER) |-> ($past(state) == ST_PREAMBLE));  // R4

    AST_DATA_FROM_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && $past(state) != ST_DATA) |-> ($past(state) == ST_TURN));  // R4

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_BASE_LOG2 = 3,
    parameter int SEL_W         = 2,
    parameter int PRE_LEN       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mgmt_en,
    input  logic [SEL_W-1:0] mdc_sel,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    output logic [CMD_W-1:0] cmd_rdata,
    output logic             idle,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    mdio_state_e      state;
    logic [IDX_W-1:0] bit_idx;
    logic [CMD_W-1:0] cmd_q;
    logic             start;
    logic             run;
    logic             is_read;
    logic             rise_tick;
    logic             bit_end;

    assign run       = (state != ST_IDLE);
    assign idle      = !run;
    assign start     = cmd_wr && mgmt_en && !run;
    assign is_read   = (cmd_q[OP_HI:OP_LO] == OP_READ);
    assign cmd_rdata = cmd_q;

    mdio_phase_gen #(
        .DIV_BASE_LOG2 (DIV_BASE_LOG2),
        .SEL_W         (SEL_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .run       (run),
        .sel       (mdc_sel),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .bit_end   (bit_end)
    );

    mdio_frame_seq #(
        .PRE_LEN (PRE_LEN)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .abort   (!mgmt_en),
        .bit_end (bit_end),
        .is_read (is_read),
        .tx_bit  (cmd_q[bit_idx]),
        .state   (state),
        .bit_idx (bit_idx),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (start) begin
            cmd_q <= cmd_wdata;
        end else if ((state == ST_DATA) && is_read && rise_tick && mgmt_en) begin
            cmd_q[bit_idx] <= mdio_i;
        end
    end

    AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cmd_wr && mgmt_en) |=> (!idle && cmd_rdata == $past(cmd_wdata)));  // R2

    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && cmd_wr) |=> (cmd_rdata[CMD_W-1:TA_LO] == $past(cmd_rdata[CMD_W-1:TA_LO])));  // R8

    AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !is_read) |=> $stable(cmd_rdata));  // R7

    AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_en |=> (idle && !mdc && !mdio_oe));  // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mdc && !mdio_oe));  // R9

    AST_RELEASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mdio_oe |-> !mdio_o);  // R10

endmodule

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgmt_en = 1'b0;
    logic [1:0]  mdc_sel = 2'd0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        idle;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    always #10 clk = ~clk;

    mdio_mgmt_master dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mgmt_en   (mgmt_en),
        .mdc_sel   (mdc_sel),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (cmd_wdata),
        .cmd_rdata (cmd_rdata),
        .idle      (idle),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    // Reference model state
    bit          m_active = 0;
    int          m_k = 0;
    int          m_div = 8;
    logic [31:0] m_cmd = '0;
    logic [31:0] m_reg = '0;
    logic [15:0] phy_val = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] rg, input logic [15:0] d);
        return {2'b01, op, phy, rg, 2'b10, d};
    endfunction

    // Model advance at the active edge; reads only bench-driven inputs
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_active = 0;
            m_k = 0;
            m_reg = '0;
        end else if (m_active && !mgmt_en) begin
            m_active = 0;
        end else if (m_active) begin
            int bn;
            int ph;
            bn = m_k / m_div;
            ph = m_k % m_div;
            if (ph == m_div / 2 - 1 && bn >= 48 && m_cmd[29:28] == 2'b10)
                m_reg[63 - bn] = mdio_i;
            if (m_k == 64 * m_div - 1) m_active = 0;
            else m_k++;
        end else if (cmd_wr && mgmt_en) begin
            m_active = 1;
            m_k = 0;
            m_div = 8 << mdc_sel;
            m_cmd = cmd_wdata;
            m_reg = cmd_wdata;
        end
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_up();
        end
    end

    // Per-cycle comparison and PHY model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit   e_mdc;
            bit   e_oe;
            bit   e_o;
            e_mdc = 0;
            e_oe = 0;
            e_o = 0;
            if (m_active) begin
                int bn;
                int ph;
                int fb;
                bn = m_k / m_div;
                ph = m_k % m_div;
                e_mdc = (ph >= m_div / 2);
                if (bn < 32) begin
                    e_oe = 1;
                    e_o = 1;
                end else begin
                    fb = 63 - bn;
                    if (m_cmd[29:28] == 2'b10 && fb <= 17) begin
                        e_oe = 0;
                        e_o = 0;
                    end else begin
                        e_oe = 1;
                        e_o = m_cmd[fb];
                    end
                end
            end
            chk(idle == !m_active, "R2/R7 idle", 32'(idle), 32'(!m_active));
            chk(mdc == e_mdc, "R3 mdc", 32'(mdc), 32'(e_mdc));
            chk(mdio_oe == e_oe, "R5/R9 mdio_oe", 32'(mdio_oe), 32'(e_oe));
            chk(mdio_o == e_o, "R4/R10 mdio_o", 32'(mdio_o), 32'(e_o));
            chk(cmd_rdata == m_reg, "R6 cmd_rdata", cmd_rdata, m_reg);
            // PHY: present the next data bit while MDC is low
            if (m_active && m_cmd[29:28] == 2'b10 && (m_k / m_div) >= 48)
                mdio_i = phy_val[63 - m_k / m_div];
            else
                mdio_i = 1'b1;
        end
    end

    task automatic launch(input logic [31:0] w, input logic [1:0] sel);
        @(negedge clk);
        cmd_wdata = w;
        mdc_sel = sel;
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_idle(output int busy);
        busy = 0;
        while (!idle && busy < 20000) begin
            busy++;
            @(negedge clk);
        end
    endtask

    initial begin
        int busy;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(idle == 1'b1, "R1 idle", 32'(idle), 32'd1);
        chk(mdc == 1'b0, "R1 mdc", 32'(mdc), 32'd0);
        chk(mdio_oe == 1'b0, "R1 mdio_oe", 32'(mdio_oe), 32'd0);
        chk(mdio_o == 1'b0, "R1 mdio_o", 32'(mdio_o), 32'd0);
        chk(cmd_rdata == 32'd0, "R1 cmd_rdata", cmd_rdata, 32'd0);
        rst_n = 1'b1;
        mgmt_en = 1'b1;
        @(negedge clk);

        // Write at ratio 8
        w = mk(2'b01, 5'd5, 5'd3, 16'hA5C3);
        launch(w, 2'd0);
        chk(cmd_rdata == w, "R2 launch", cmd_rdata, w);
        wait_idle(busy);
        chk(busy == 512, "R7 frame length div8", busy, 512);
        chk(cmd_rdata == w, "R7 write keeps word", cmd_rdata, w);

        // Read at ratio 16
        phy_val = 16'h1234;
        w = mk(2'b10, 5'd1, 5'd2, 16'h0000);
        launch(w, 2'd1);
        wait_idle(busy);
        chk(busy == 1024, "R7 frame length div16", busy, 1024);
        chk(cmd_rdata == {w[31:16], 16'h1234}, "R6 read value", cmd_rdata, {w[31:16], 16'h1234});

        // Read at ratio 64
        phy_val = 16'hBEEF;
        w = mk(2'b10, 5'd31, 5'd31, 16'h5555);
        launch(w, 2'd3);
        wait_idle(busy);
        chk(busy == 4096, "R3 frame length div64", busy, 4096);
        chk(cmd_rdata == {w[31:16], 16'hBEEF}, "R6 read value div64", cmd_rdata, {w[31:16], 16'hBEEF});

        // Read returning all ones, then all zeros
        phy_val = 16'hFFFF;
        w = mk(2'b10, 5'd0, 5'd0, 16'h0000);
        launch(w, 2'd0);
        wait_idle(busy);
        chk(cmd_rdata[15:0] == 16'hFFFF, "R6 read ones", cmd_rdata, {w[31:16], 16'hFFFF});
        phy_val = 16'h0000;
        w = mk(2'b10, 5'd9, 5'd17, 16'hFFFF);
        launch(w, 2'd0);
        wait_idle(busy);
        chk(cmd_rdata == {w[31:16], 16'h0000}, "R6 read zeros", cmd_rdata, {w[31:16], 16'h0000});

        // Write at ratio 32, selector changed and a busy write mid-frame
        w = mk(2'b01, 5'd12, 5'd7, 16'h0F0F);
        launch(w, 2'd2);
        repeat (100) @(negedge clk);
        mdc_sel = 2'd0;
        repeat (100) @(negedge clk);
        cmd_wdata = mk(2'b10, 5'd3, 5'd3, 16'hFFFF);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(cmd_rdata == w, "R8 busy write ignored", cmd_rdata, w);
        wait_idle(busy);
        chk(busy == 2048 - 201, "R3 selector latched", busy, 2048 - 201);
        chk(cmd_rdata == w, "R8 word after frame", cmd_rdata, w);

        // Disabled port: no launch
        mgmt_en = 1'b0;
        launch(mk(2'b01, 5'd1, 5'd1, 16'h1111), 2'd0);
        chk(idle == 1'b1, "R9 no launch when disabled", 32'(idle), 32'd1);
        chk(cmd_rdata == w, "R9 word kept when disabled", cmd_rdata, w);

        // Abort mid-frame
        mgmt_en = 1'b1;
        w = mk(2'b01, 5'd2, 5'd4, 16'hC3C3);
        launch(w, 2'd1);
        repeat (300) @(negedge clk);
        mgmt_en = 1'b0;
        @(negedge clk);
        chk(idle == 1'b1, "R9 abort idle", 32'(idle), 32'd1);
        chk(mdc == 1'b0, "R9 abort mdc", 32'(mdc), 32'd0);
        chk(mdio_oe == 1'b0, "R9 abort release", 32'(mdio_oe), 32'd0);
        mgmt_en = 1'b1;

        // Fresh frame after abort
        w = mk(2'b01, 5'd30, 5'd1, 16'h8001);
        launch(w, 2'd0);
        wait_idle(busy);
        chk(busy == 512, "R7 frame after abort", busy, 512);
        repeat (5) @(negedge clk);
        finish_up();
    end

endmodule